// File: doc/BRIEF.md
# Double-Buffered Parallel-to-Serial Converter

This block turns a parallel word into a serial bit stream through two register stages. A holding register latches the parallel inputs whenever its capture strobe is high. A second register, the shift chain, can then be filled from the holding register, forced to zero, or advanced by one stage per shift strobe. Its most significant stage drives the serial output, so a word leaves the block MSB first.

Because the holding register is separate from the shift chain, the next word can be captured while the current one is still being shifted out. The serial fill input lets several instances be chained: the serial output of one instance drives the fill input of the next, and the pair behaves as one wider shift chain. Everything is synchronous to one clock. The strobes act as single-cycle clock enables, and the two active-low controls are sampled on every edge. The strobes and controls are plain level pins with no valid/ready handshake: the block cannot stall, so one strobe is always one action.

Asserting the clear and the load together is not a meaningful request. The block resolves it as a clear and raises a status pin for as long as the combination is present.

Top module: `piso_dbuf`

## Requirements
- R1: On a clock edge with `cap_en` high, the holding register takes `par_in`. Without `cap_en` it keeps its value whatever `shift_en`, `load_n` or `clr_n` do.
- R2: On an edge with `load_n` low and `clr_n` high, the shift chain takes the holding register contents, even if `shift_en` is high.
- R3: If `cap_en` is high on the same edge as a load, the shift chain takes `par_in` directly, and the holding register takes it as well.
- R4: On an edge with `clr_n` low, every stage of the shift chain becomes 0, even if `shift_en` is high. The holding register is not changed.
- R5: On an edge with `shift_en` high and both `load_n` and `clr_n` high, stage n takes stage n-1 and stage 0 takes `fill_in`. `ser_out` is stage W-1, so a loaded word appears bit W-1 first.
- R6: When `load_n` and `clr_n` are both low, the clear wins. `illegal_ctrl` is high in exactly the cycles in which both are low.
- R7: After `rst_n` is asserted, both registers hold zero and `ser_out` is 0.
- R8: On an edge with `shift_en` low and both controls high, the shift chain keeps its value.
- R9: When one instance's `ser_out` drives a second instance's `fill_in` and both share strobes, shifting yields a 2W-bit stream, MSB first, with the second instance's word in the upper half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| par_in | input | W | Parallel data word |
| fill_in | input | 1 | Serial input into stage 0 |
| cap_en | input | 1 | Capture strobe for the holding register |
| shift_en | input | 1 | Shift strobe for the shift chain |
| load_n | input | 1 | Load shift chain from holding register, active low |
| clr_n | input | 1 | Clear shift chain, active low |
| ser_out | output | 1 | Serial output, stage W-1 |
| illegal_ctrl | output | 1 | High while load and clear are both asserted |

## Verification
Words with alternating, single-one and all-ones patterns are loaded and shifted out. These show bit order and whether a stage is stuck or swapped. A fill stream that differs from the loaded word shows that stage 0 takes the fill bit and not a recirculated one. A word is captured and then followed by clears and shifts before it is reloaded; this separates the holding register from the chain. Capture-with-load, load-with-shift, clear-with-shift and load-with-clear cycles, two chained instances and a long random stretch exercise the priority and cascade rules, all compared each cycle against a bit-queue model.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_SHIFT = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } chain_act_e;
endpackage

// File: rtl/piso_ctrl_arb.sv
module piso_ctrl_arb
  import piso_pkg::*;
(
  input  logic       shift_en,
  input  logic       load_n,
  input  logic       clr_n,
  output chain_act_e act,
  output logic       conflict
);
  always_comb begin
    conflict = ~load_n & ~clr_n;
    if (!clr_n)        act = ACT_CLEAR;
    else if (!load_n)  act = ACT_LOAD;
    else if (shift_en) act = ACT_SHIFT;
    else               act = ACT_HOLD;
  end
endmodule

// File: rtl/piso_hold_reg.sv
module piso_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (cap_en) q <= d;
  end
endmodule

// File: rtl/piso_shift_chain.sv
module piso_shift_chain
  import piso_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  chain_act_e   act,
  input  logic [W-1:0] load_word,
  input  logic         fill_in,
  output logic [W-1:0] q
);
  logic [W:0] prev;
  assign prev = {q, fill_in};

  for (genvar i = 0; i < W; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else begin
        case (act)
          ACT_CLEAR: q[i] <= 1'b0;
          ACT_LOAD:  q[i] <= load_word[i];
          ACT_SHIFT: q[i] <= prev[i];
          default:   q[i] <= q[i];
        endcase
      end
    end
  end
endmodule

// File: rtl/piso_dbuf.sv
module piso_dbuf
  import piso_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] par_in,
  input  logic         fill_in,
  input  logic         cap_en,
  input  logic         shift_en,
  input  logic         load_n,
  input  logic         clr_n,
  output logic         ser_out,
  output logic         illegal_ctrl
);
  logic [W-1:0] store_q;
  logic [W-1:0] chain_q;
  logic [W-1:0] load_word;
  chain_act_e   act;

  piso_hold_reg #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .d(par_in), .q(store_q)
  );

  piso_ctrl_arb u_arb (
    .shift_en(shift_en), .load_n(load_n), .clr_n(clr_n),
    .act(act), .conflict(illegal_ctrl)
  );

  // same-edge capture bypasses the holding register into the chain
  assign load_word = cap_en ? par_in : store_q;

  piso_shift_chain #(.W(W)) u_chain (
    .clk(clk), .rst_n(rst_n), .act(act), .load_word(load_word),
    .fill_in(fill_in), .q(chain_q)
  );

  assign ser_out = chain_q[W-1];
endmodule

// File: rtl/piso_dbuf_chk.sv
module piso_dbuf_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] par_in,
  input logic         fill_in,
  input logic         cap_en,
  input logic         shift_en,
  input logic         load_n,
  input logic         clr_n,
  input logic         illegal_ctrl,
  input logic [W-1:0] store,
  input logic [W-1:0] chain
);
  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> store == $past(par_in));
  a_r1_store_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(store));
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && clr_n && !cap_en) |=> chain == $past(store));
  a_r3_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && clr_n && cap_en) |=> chain == $past(par_in));
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> chain == '0);
  a_r5_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && load_n && clr_n) |=> chain == {$past(chain[W-2:0]), $past(fill_in)});
  a_r6_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_ctrl |=> chain == '0);
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && load_n && clr_n) |=> $stable(chain));
endmodule

bind piso_dbuf piso_dbuf_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .par_in(par_in), .fill_in(fill_in),
  .cap_en(cap_en), .shift_en(shift_en), .load_n(load_n), .clr_n(clr_n),
  .illegal_ctrl(illegal_ctrl), .store(store_q), .chain(chain_q)
);

// File: tb/piso_dbuf_tb.sv
module piso_dbuf_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] par_in = '0, par_hi = '0;
  logic fill_in = 1'b0, cap_en = 1'b0, shift_en = 1'b0, load_n = 1'b1, clr_n = 1'b1;
  logic ser_out, illegal_ctrl, ser_hi, illegal_hi;

  int vectors = 0;
  int errors = 0;

  // reference model: queue front is the serial output stage
  logic mq[$];
  logic hq[$];
  int   m_store = 0;
  int   h_store = 0;

  always #4 clk = ~clk;

  piso_dbuf #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .par_in(par_in), .fill_in(fill_in),
    .cap_en(cap_en), .shift_en(shift_en), .load_n(load_n), .clr_n(clr_n),
    .ser_out(ser_out), .illegal_ctrl(illegal_ctrl)
  );

  // upper instance for the cascade (R9): fed from u_dut's serial output
  piso_dbuf #(.W(W)) u_hi (
    .clk(clk), .rst_n(rst_n), .par_in(par_hi), .fill_in(ser_out),
    .cap_en(cap_en), .shift_en(shift_en), .load_n(load_n), .clr_n(clr_n),
    .ser_out(ser_hi), .illegal_ctrl(illegal_hi)
  );

  task automatic check(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    mq.delete(); hq.delete();
    for (int i = 0; i < W; i++) begin mq.push_back(1'b0); hq.push_back(1'b0); end
    m_store = 0; h_store = 0;
  endtask

  function automatic void model_step(ref logic q[$], ref int st, input int par, input logic fill);
    int src;
    src = cap_en ? par : st;
    if (!clr_n) begin
      for (int i = 0; i < W; i++) q[i] = 1'b0;
    end else if (!load_n) begin
      q.delete();
      for (int i = W - 1; i >= 0; i--) q.push_back(src[i]);
    end else if (shift_en) begin
      void'(q.pop_front());
      q.push_back(fill);
    end
    if (cap_en) st = par;
  endfunction

  // drive one cycle of stimulus, then compare after the edge
  task automatic cyc(string tag, logic cap, logic sh, logic ld_n, logic cl_n,
                     logic [W-1:0] p, logic f, logic [W-1:0] ph = '0);
    logic lo_front;
    cap_en = cap; shift_en = sh; load_n = ld_n; clr_n = cl_n;
    par_in = p; fill_in = f; par_hi = ph;
    #1;
    check("R6 illegal_ctrl", illegal_ctrl, ~ld_n & ~cl_n);
    lo_front = mq[0];
    model_step(mq, m_store, int'(p), f);
    model_step(hq, h_store, int'(ph), lo_front);
    @(posedge clk);
    @(negedge clk);
    check(tag, ser_out, mq[0]);
    check({tag, " cascade R9"}, ser_hi, hq[0]);
  endtask

  initial begin : watchdog
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R7 reset ser_out", ser_out, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: load without capture must give zeros from the cleared store
    cyc("R7 store zero", 0, 0, 0, 1, 8'hFF, 1);
    for (int i = 0; i < W; i++) cyc("R7 zero shift", 0, 1, 1, 1, 8'h00, 0);

    // R1, R2, R5: capture, load, shift out with fill pattern
    cyc("R1 capture", 1, 0, 1, 1, 8'hA5, 0);
    cyc("R2 load", 0, 1, 0, 1, 8'h00, 0);
    for (int i = 0; i < W + 2; i++) cyc("R5 shift A5", 0, 1, 1, 1, 8'h3C, i[0]);

    // R1, R4: capture, then clear and shift must not touch storage
    cyc("R1 capture 81", 1, 0, 1, 1, 8'h81, 0);
    cyc("R4 clear with shift", 0, 1, 1, 0, 8'h00, 1);
    cyc("R8 idle", 0, 0, 1, 1, 8'hFF, 1);
    cyc("R8 idle2", 0, 0, 1, 1, 8'h00, 1);
    cyc("R1 store kept", 0, 0, 0, 1, 8'h00, 0);
    for (int i = 0; i < W; i++) cyc("R5 shift 81", 0, 1, 1, 1, 8'hFF, 1);

    // R3: capture and load on the same edge
    cyc("R3 bypass", 1, 0, 0, 1, 8'h6E, 0, 8'hC3);
    for (int i = 0; i < 2 * W; i++) cyc("R9 cascade 16", 0, 1, 1, 1, 8'h00, 0);

    // R6: load and clear together, clear wins
    cyc("R1 capture FF", 1, 0, 1, 1, 8'hFF, 0, 8'hFF);
    cyc("R2 load FF", 0, 0, 0, 1, 8'h00, 0);
    cyc("R6 both asserted", 0, 1, 0, 0, 8'h00, 1);
    cyc("R8 hold after clear", 0, 0, 1, 1, 8'h00, 0);
    cyc("R2 load over shift", 0, 1, 0, 1, 8'h00, 0);
    for (int i = 0; i < W; i++) cyc("R5 ones", 0, 1, 1, 1, 8'h00, 0);

    // single-one walking words
    for (int b = 0; b < W; b++) begin
      cyc("R3 walk load", 1, 0, 0, 1, 8'(1 << b), 0, 8'(8'h80 >> b));
      for (int i = 0; i < W; i++) cyc("R5 walk", 0, 1, 1, 1, 8'h00, 0);
    end

    // random stretch
    for (int n = 0; n < 2000; n++) begin
      int r;
      r = $urandom;
      cyc("R1-random", r[0], r[1], r[4:2] != 0, r[7:5] != 0,
          8'($urandom), r[8], 8'($urandom));
    end

    // R7: reset mid-stream
    cyc("R2 pre reset", 1, 0, 0, 1, 8'hF0, 0, 8'h0F);
    rst_n = 1'b0;
    #1;
    model_reset();
    check("R7 async reset", ser_out, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc("R7 store cleared", 0, 0, 0, 1, 8'h00, 0);
    for (int i = 0; i < W; i++) cyc("R7 zero out", 0, 1, 1, 1, 8'h00, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule